// File: doc/BRIEF.md
# Temperature Conversion Request Scheduler

This block decides when a temperature conversion, with the compensation update that follows it, is launched. Requests come from two places. One is an internal periodic trigger. The other is software, which writes 1 to a convert bit in the control register. The block sends a one-cycle start pulse to an external conversion engine and waits for that engine's done pulse. While it waits, it shows a busy status.

The convert bit tells software that its request is still in flight. It reads 1 from the accepted write until the conversion serving that request completes. It then clears in the same cycle as busy.

Runs are spaced by a 1 Hz tick. After a start, no new start is issued until `MIN_TICK_GAP` ticks have arrived (default 1). A request that comes in during that window waits. Periodic and software requests are held in separate pending flags. Neither can cancel the other, and when both are pending at a launch, a single conversion serves both.

Top module: `convsched_top`

## Requirements
- R1: After reset, `convBit`, `busy` and `convStart` are all 0.
- R2: A write with `regWrConv`=1 while `convBit` is 0 sets `convBit` in the next cycle. A write with `regWrConv`=0 has no effect. A write of 1 while `convBit` is already 1 has no effect and does not queue a second request.
- R3: `convBit` stays 1 until `convDone` is seen while busy for the conversion serving it. `convBit` and `busy` then both read 0 in the next cycle.
- R4: `convStart` is a single-cycle pulse, and `busy` rises in the same cycle. `busy` stays 1 until the cycle after a `convDone` and applies to periodic conversions as well as requested ones. A `convDone` while not busy is ignored.
- R5: Between two `convStart` pulses at least `MIN_TICK_GAP` ticks of `tick1Hz` arrive. A tick in the cycle that launches counts toward the earlier window.
- R6: A request made while the spacing window is closed is held pending. It launches in the cycle the closing tick arrives, so `convStart` is seen in the next cycle.
- R7: A periodic trigger is never dropped. A trigger that arrives while a conversion is running, or while software requests are active, is served by a later conversion. A periodic-only conversion leaves `convBit` at 0.
- R8: A periodic request and a software request that are both pending at a launch are served by one conversion. Its completion clears `convBit`, and no second start follows for either request.
- R9: With the block idle and the window open, a pending request produces `convStart` one cycle after it is registered. For a write, that is two cycles after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrConv | input | 1 | Value written to the convert bit |
| periodicTrig | input | 1 | Internal periodic conversion trigger pulse |
| tick1Hz | input | 1 | One-second tick pulse |
| convDone | input | 1 | Conversion engine done pulse |
| convStart | output | 1 | One-cycle start pulse to the conversion engine |
| busy | output | 1 | Conversion in progress |
| convBit | output | 1 | Convert bit read value |

## Verification
Directed sequences run the block from reset through five patterns:
- A lone software request with the window open, which exposes the start latency.
- A request made inside the spacing window, which tells holding apart from starting at once.
- A trigger and a write that coincide, which tells a merged conversion apart from two back-to-back ones.
- A trigger that arrives during a running conversion, which tells a retained request apart from a dropped one.
- Writes of 0, and repeated writes of 1 while the bit is set, which show that neither changes the queue.

A long constrained-random phase then mixes writes, triggers, ticks, engine latencies and stray done pulses. The outputs are compared every cycle against a cycle-level model of the requirements.

// File: rtl/convsched_pkg.sv
package convsched_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic launch;  // a conversion starts this cycle
    logic finish;  // the running conversion completes this cycle
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic anyPend;  // a periodic or software request is waiting
    logic gapOpen;  // spacing window allows a launch this cycle
  } dpStatus_t;
endpackage

// File: rtl/convsched_dp.sv
module convsched_dp
  import convsched_pkg::*;
#(
  parameter int MIN_TICK_GAP = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regWrConv,
  input  logic        periodicTrig,
  input  logic        tick1Hz,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        convBit
);
  localparam int GAP_W = $clog2(MIN_TICK_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_TICK_GAP);
  localparam logic [GAP_W-1:0] GAP_ONE  = GAP_W'(1);

  logic             swPend;    // software request waiting for launch
  logic             swActive;  // software request carried by running conversion
  logic             perPend;   // periodic request waiting for launch
  logic [GAP_W-1:0] gapCnt;    // ticks still required before next launch
  logic             swAccept;

  assign convBit  = swPend | swActive;
  assign swAccept = regWrEn & regWrConv & ~convBit;

  always_comb begin
    status.anyPend = swPend | perPend;
    status.gapOpen = (gapCnt == '0) | ((gapCnt == GAP_ONE) & tick1Hz);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swPend   <= 1'b0;
      swActive <= 1'b0;
      perPend  <= 1'b0;
    end else begin
      if (swAccept)           swPend <= 1'b1;
      else if (strobe.launch) swPend <= 1'b0;

      if (strobe.launch)      swActive <= swPend;
      else if (strobe.finish) swActive <= 1'b0;

      if (periodicTrig)       perPend <= 1'b1;
      else if (strobe.launch) perPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        gapCnt <= '0;
    else if (strobe.launch)           gapCnt <= GAP_LOAD;
    else if (tick1Hz && gapCnt != '0) gapCnt <= gapCnt - GAP_ONE;
  end
endmodule

// File: rtl/convsched_ctrl.sv
module convsched_ctrl
  import convsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        convDone,
  output ctrlStrobe_t strobe,
  output logic        convStart,
  output logic        busy
);
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_t;
  state_t state;

  always_comb begin
    strobe.launch = (state == ST_IDLE) & status.anyPend & status.gapOpen;
    strobe.finish = (state == ST_RUN) & convDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convStart <= 1'b0;
    end else begin
      convStart <= strobe.launch;
      if (strobe.launch)      state <= ST_RUN;
      else if (strobe.finish) state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/convsched_top.sv
module convsched_top
  import convsched_pkg::*;
#(
  parameter int MIN_TICK_GAP = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regWrConv,
  input  logic periodicTrig,
  input  logic tick1Hz,
  input  logic convDone,
  output logic convStart,
  output logic busy,
  output logic convBit
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  convsched_dp #(.MIN_TICK_GAP(MIN_TICK_GAP)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrConv(regWrConv),
    .periodicTrig(periodicTrig), .tick1Hz(tick1Hz), .strobe(strobe),
    .status(status), .convBit(convBit)
  );

  convsched_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .status(status), .convDone(convDone),
    .strobe(strobe), .convStart(convStart), .busy(busy)
  );
endmodule

// File: rtl/convsched_chk.sv
module convsched_chk #(
  parameter int MIN_TICK_GAP = 1
) (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic regWrConv,
  input logic tick1Hz,
  input logic convDone,
  input logic convStart,
  input logic busy,
  input logic convBit
);
  localparam int CW = $clog2(MIN_TICK_GAP + 2);
  localparam logic [CW-1:0] CMAX = CW'(MIN_TICK_GAP);

  logic [CW-1:0] tickCnt;  // ticks seen since last start, saturating
  logic          started;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      started <= 1'b0;
    end else if (convStart) begin
      started <= 1'b1;
      tickCnt <= tick1Hz ? CW'(1) : '0;
    end else if (tick1Hz && tickCnt < CMAX) begin
      tickCnt <= tickCnt + CW'(1);
    end
  end

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);  // R4
  AST_BUSY_RISE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> convStart);  // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);  // R4
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busy && convDone |=> !busy);  // R3
  AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    convBit && !(busy && convDone) |=> convBit);  // R3
  AST_CONV_FALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convBit) |-> $fell(busy));  // R3
  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regWrConv && !convBit |=> convBit);  // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    !convBit && !(regWrEn && regWrConv) |=> !convBit);  // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    convStart && started |-> tickCnt >= CMAX);  // R5
endmodule

bind convsched_top convsched_chk #(.MIN_TICK_GAP(MIN_TICK_GAP)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrConv(regWrConv),
  .tick1Hz(tick1Hz), .convDone(convDone), .convStart(convStart),
  .busy(busy), .convBit(convBit)
);

// File: tb/convsched_tb.sv
`timescale 1ns/1ps
module convsched_top_tb_top;
  localparam int GAP = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regWrConv = 0, periodicTrig = 0, tick1Hz = 0, convDone = 0;
  logic convStart, busy, convBit;

  int checks = 0;
  int failures = 0;
  int dutStarts = 0;

  // reference model state
  logic mSwPend = 0, mSwAct = 0, mPerPend = 0, mBusy = 0, mStart = 0;
  int   mGap = 0;

  always #10 clk = ~clk;

  convsched_top #(.MIN_TICK_GAP(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrConv(regWrConv),
    .periodicTrig(periodicTrig), .tick1Hz(tick1Hz), .convDone(convDone),
    .convStart(convStart), .busy(busy), .convBit(convBit)
  );

  function automatic logic expConv();
    return mSwPend | mSwAct;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: drive inputs, advance model, compare at negedge
  task automatic cyc(input logic wr, input logic d, input logic trg,
                     input logic tk, input logic dn);
    logic allow, launch, finish, conv;
    logic nSwPend, nSwAct, nPer, nBusy;
    int nGap;
    regWrEn = wr; regWrConv = d; periodicTrig = trg; tick1Hz = tk; convDone = dn;
    allow  = (mGap == 0) || (mGap == 1 && tk);
    launch = !mBusy && (mSwPend || mPerPend) && allow;
    finish = mBusy && dn;
    conv   = expConv();
    nSwAct  = launch ? mSwPend : (finish ? 1'b0 : mSwAct);
    nSwPend = (wr && d && !conv) ? 1'b1 : (launch ? 1'b0 : mSwPend);
    nPer    = trg ? 1'b1 : (launch ? 1'b0 : mPerPend);
    nBusy   = launch ? 1'b1 : (finish ? 1'b0 : mBusy);
    nGap    = launch ? GAP : ((tk && mGap > 0) ? mGap - 1 : mGap);
    @(posedge clk);
    @(negedge clk);
    mSwPend = nSwPend; mSwAct = nSwAct; mPerPend = nPer; mBusy = nBusy;
    mStart = launch; mGap = nGap;
    if (convStart) dutStarts++;
    chk("R3 convBit", convBit, expConv());
    chk("R4 busy", busy, mBusy);
    chk("R5 convStart", convStart, mStart);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cd;
    int startsBefore;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 convBit", convBit, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 convStart", convStart, 1'b0);

    // R2: write of 0 has no effect
    cyc(1, 0, 0, 0, 0);
    chk("R2 write0", convBit, 1'b0);

    // R9: request with window open starts one cycle after being registered
    cyc(1, 1, 0, 0, 0);
    chk("R2 write1", convBit, 1'b1);
    chk("R9 no start yet", convStart, 1'b0);
    cyc(0, 0, 0, 0, 0);
    chk("R9 start", convStart, 1'b1);
    chk("R4 busy with start", busy, 1'b1);

    // R2: writes while set change nothing
    cyc(1, 0, 0, 0, 0);
    chk("R2 write0 while set", convBit, 1'b1);
    cyc(1, 1, 0, 0, 0);
    chk("R2 write1 while set", convBit, 1'b1);
    cyc(0, 0, 0, 0, 1);
    chk("R3 convBit clear", convBit, 1'b0);
    chk("R3 busy clear", busy, 1'b0);
    startsBefore = dutStarts;
    idle(3);
    chk("R2 no queued request", (dutStarts == startsBefore), 1'b1);

    // R6: request inside window held until tick
    cyc(1, 1, 0, 0, 0);
    idle(4);
    chk("R6 held", busy, 1'b0);
    chk("R6 pending bit", convBit, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 start after tick", convStart, 1'b1);
    idle(2);
    cyc(0, 0, 0, 0, 1);

    // R8: coincident periodic and software served by one conversion
    startsBefore = dutStarts;
    cyc(1, 1, 1, 0, 0);
    idle(2);
    cyc(0, 0, 0, 1, 0);
    chk("R8 start", convStart, 1'b1);
    idle(2);
    cyc(0, 0, 0, 0, 1);
    chk("R8 convBit clear", convBit, 1'b0);
    idle(2);
    cyc(0, 0, 0, 1, 0);
    idle(3);
    chk("R8 single start", (dutStarts - startsBefore == 1), 1'b1);

    // R7: trigger during busy is retained; periodic leaves convBit 0
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 periodic start", convStart, 1'b1);
    chk("R7 convBit stays 0", convBit, 1'b0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 busy drops", busy, 1'b0);
    cyc(0, 0, 0, 1, 0);
    chk("R7 retained trigger served", convStart, 1'b1);
    cyc(0, 0, 0, 0, 1);

    // R4: stray done while idle ignored
    cyc(0, 0, 0, 0, 1);
    chk("R4 stray done", busy, 1'b0);

    // constrained random phase
    cd = 0;
    for (int n = 0; n < 6000; n++) begin
      logic wr, d, trg, tk, dn;
      wr  = ($urandom % 8) == 0;
      d   = ($urandom % 2) == 0;
      trg = ($urandom % 40) == 0;
      tk  = ($urandom % 16) == 0;
      dn  = 1'b0;
      if (mBusy) begin
        if (cd == 0) cd = 2 + ($urandom % 5);
        cd--;
        dn = (cd == 0);
      end else begin
        cd = 0;
        dn = ($urandom % 50) == 0;
      end
      cyc(wr, d, trg, tk, dn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule